// File: doc/BRIEF.md
# Store Miss Merge Buffer

This block sits between a store pipeline and the system bus. It takes stores that missed in the data cache and gathers them into a small set of line-sized entries, one entry per line address. Each entry keeps a byte-valid mask for the bytes written so far. Later stores to the same line land in the same entry. They do not queue for a separate line fill.

An entry closes once its line is complete or once a fixed time has passed since its first store. At that point the block picks how the line is obtained. If every byte of the line has been written, nothing needs to be read from memory, so it sends an address-only ownership claim. If coverage is partial, it sends a full line read. When the fill returns, the written bytes take precedence over the fetched bytes. In both cases the finished line goes to the cache through a write port, and the entry is then free again.

Stores are doubleword sized: a word address, a byte-enable per byte, and the data. Store, bus-request and cache-write interfaces use valid/ready handshakes. Fills are matched to entries by a tag that the block returns with each bus request.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the block raises no bus request and no cache write, and it accepts stores (store ready high).
- R2: Stores to one line while its entry is open all merge into that entry, and that line produces exactly one bus transaction.
- R3: If the merged byte mask covers all 32 bytes, the entry requests in the cycle after the completing store is accepted. The request has kind 1 (address-only claim) and needs no fill. The cache write that follows carries the stored bytes, with doubleword slot k at line bits [64k+63:64k].
- R4: If coverage is partial when the entry closes, the request has kind 0 (line read). The cache write carries the fill data with every stored byte replacing the fetched byte in its position.
- R5: When two stores write the same byte of an open entry, the younger store's value is the one written to the cache.
- R6: An entry that is not fully covered closes and raises its read request exactly TIMEOUT cycles after the cycle its first store was accepted, and not earlier.
- R7: From the moment an entry closes until its cache write completes, a store to that entry's line is stalled (store ready low). It is accepted once the entry has retired.
- R8: With all entries occupied, a store to a line not held is stalled, while a store to a line held in an open entry is still accepted.
- R9: A bus request or cache write, once raised, keeps its line, kind, tag and data stable until it is accepted. Among waiting entries, the lowest entry index is served first.
- R10: A fill is delivered to the entry named by its tag, whatever order fills return in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store miss presented |
| st_waddr | input | ADDR_W-3 | Store doubleword address (low bits select the slot in the line) |
| st_be | input | 8 | Byte enables of the store, bit b for byte b of the doubleword |
| st_data | input | 64 | Store data, byte b at bits [8b+7:8b] |
| st_ready | output | 1 | Store accepted this cycle when valid |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_kind | output | 1 | 0 = line read, 1 = address-only ownership claim |
| bus_req_line | output | ADDR_W-5 | Line address of the request |
| bus_req_tag | output | log2(ENTRIES) | Entry index to be quoted by the fill |
| fill_valid | input | 1 | Read data returning |
| fill_tag | input | log2(ENTRIES) | Entry the fill belongs to |
| fill_data | input | 256 | Fetched line, byte n at bits [8n+7:8n] |
| cw_valid | output | 1 | Completed line ready for the cache |
| cw_ready | input | 1 | Cache accepts the line |
| cw_line | output | ADDR_W-5 | Line address written to the cache |
| cw_data | output | 256 | Merged line contents |

## Verification
Most internal faults surface quickly at the ports. A wrong byte mask shows up in the request kind, and a wrong merge or override rule shows up in the bytes of the cache write. Either is visible one cycle after the request is accepted for a claim, or one cycle after the fill for a read. A bad age counter moves the read request away from its exact TIMEOUT cycle. A stuck entry state shows as store ready staying low for its line after the cache write, or as a second bus transaction for a line that should have merged. Fills answered in reverse order expose tag routing errors in the data written for each line.

// File: rtl/smb_pkg.sv
// Shared types for the store miss merge buffer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package smb_pkg;

    // Life cycle of one merge entry.
    typedef enum logic [2:0] {
        E_FREE = 3'd0,   // holds nothing
        E_OPEN = 3'd1,   // collecting stores
        E_REQ  = 3'd2,   // closed, bus request raised
        E_WAIT = 3'd3,   // read accepted, waiting for fill
        E_WB   = 3'd4    // line complete, writing to cache
    } ent_st_t;

    localparam logic KIND_READ  = 1'b0;
    localparam logic KIND_CLAIM = 1'b1;

endpackage

// File: rtl/smb_pick.sv
// Lowest-index picker with hold: picks the lowest set request and keeps
// that choice until the consumer acknowledges it.
// Assumes: a request that is being held stays set until acknowledged.
module smb_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          ack,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic          hold_q;
    logic [IW-1:0] hold_idx_q;
    logic [IW-1:0] low_idx;

    // Scan for the lowest requesting index.
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) low_idx = IW'(i);
        end
    end

    assign any = |req;
    assign idx = hold_q ? hold_idx_q : low_idx;

    // Remember an offered choice that was not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= any & ~ack;
            hold_idx_q <= idx;
        end
    end
endmodule

// File: rtl/smb_match.sv
// Line address lookup: compares a probe line against every entry and
// reports hits on open entries and on closed (busy) entries separately.
// Assumes: at most one non-free entry holds any given line.
module smb_match #(
    parameter int N    = 4,
    parameter int LA_W = 27
) (
    input  logic [LA_W-1:0]     probe_line,
    input  smb_pkg::ent_st_t    st_vec   [N],
    input  logic [LA_W-1:0]     line_vec [N],
    output logic [N-1:0]        hit_open,
    output logic [N-1:0]        hit_busy
);
    import smb_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic same;
        // Address equality for this entry.
        assign same        = (line_vec[i] == probe_line);
        // Open entries accept merges.
        assign hit_open[i] = same && (st_vec[i] == E_OPEN);
        // Closed entries block stores to their line.
        assign hit_busy[i] = same && (st_vec[i] != E_OPEN) && (st_vec[i] != E_FREE);
    end
endmodule

// File: rtl/smb_entry.sv
// One merge entry: line address, byte-valid mask, line data, age counter
// and the state machine that closes, issues, absorbs the fill and retires.
// Assumes: alloc only while free, merge only while open, fill_hit only while
// waiting; issue_gnt and wb_done only in the matching state.
module smb_entry #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    parameter int LA_W       = 27,
    parameter int TIMEOUT    = 16,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int SLOT_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int AGE_W     = $clog2(TIMEOUT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  merge,
    input  logic [LA_W-1:0]       st_line,
    input  logic [SLOT_W-1:0]     st_slot,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic [WORD_W-1:0]     st_data,
    input  logic                  issue_gnt,
    input  logic                  fill_hit,
    input  logic [LINE_W-1:0]     fill_data,
    input  logic                  wb_done,
    output smb_pkg::ent_st_t      st_o,
    output logic [LA_W-1:0]       line_o,
    output logic                  kind_o,
    output logic [LINE_W-1:0]     data_o
);
    import smb_pkg::*;

    ent_st_t               state_q;
    logic [LA_W-1:0]       line_q;
    logic [LINE_BYTES-1:0] mask_q;
    logic [LINE_W-1:0]     data_q;
    logic [AGE_W-1:0]      age_q;
    logic                  kind_q;

    logic [LINE_BYTES-1:0] wr_mask;
    logic [LINE_BYTES-1:0] nxt_mask;
    logic [LINE_W-1:0]     nxt_data;
    logic [LINE_W-1:0]     fill_merged;
    logic                  wr_en;
    logic                  full;

    assign wr_en = alloc | merge;

    // Spread the store's byte enables onto the line byte positions.
    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            wr_mask[b] = (SLOT_W'(b / WORD_BYTES) == st_slot) && st_be[b % WORD_BYTES];
        end
    end

    // Mask and data after applying this cycle's store (younger bytes win).
    always_comb begin
        nxt_mask = ((state_q == E_FREE) ? '0 : mask_q) | (wr_en ? wr_mask : '0);
        for (int b = 0; b < LINE_BYTES; b++) begin
            nxt_data[b*8 +: 8] = (wr_en && wr_mask[b]) ? st_data[(b % WORD_BYTES)*8 +: 8]
                                                       : data_q[b*8 +: 8];
        end
    end

    assign full = &nxt_mask;

    // Fetched bytes fill only the positions no store has written.
    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            fill_merged[b*8 +: 8] = mask_q[b] ? data_q[b*8 +: 8] : fill_data[b*8 +: 8];
        end
    end

    // Entry state machine and storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_FREE;
            line_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            age_q   <= '0;
            kind_q  <= KIND_READ;
        end else begin
            case (state_q)
                E_FREE: begin
                    if (alloc) begin
                        line_q <= st_line;
                        mask_q <= nxt_mask;
                        data_q <= nxt_data;
                        age_q  <= '0;
                        if (full) begin
                            state_q <= E_REQ;
                            kind_q  <= KIND_CLAIM;
                        end else begin
                            state_q <= E_OPEN;
                        end
                    end
                end
                E_OPEN: begin
                    mask_q <= nxt_mask;
                    data_q <= nxt_data;
                    if (full) begin
                        state_q <= E_REQ;
                        kind_q  <= KIND_CLAIM;
                    end else if (age_q == AGE_W'(TIMEOUT - 1)) begin
                        state_q <= E_REQ;
                        kind_q  <= KIND_READ;
                    end else begin
                        age_q <= age_q + 1'b1;
                    end
                end
                E_REQ: begin
                    if (issue_gnt) state_q <= (kind_q == KIND_CLAIM) ? E_WB : E_WAIT;
                end
                E_WAIT: begin
                    if (fill_hit) begin
                        data_q  <= fill_merged;
                        state_q <= E_WB;
                    end
                end
                E_WB: begin
                    if (wb_done) begin
                        state_q <= E_FREE;
                        mask_q  <= '0;
                    end
                end
                default: state_q <= E_FREE;
            endcase
        end
    end

    assign st_o   = state_q;
    assign line_o = line_q;
    assign kind_o = kind_q;
    assign data_o = data_q;
endmodule

// File: rtl/store_merge_buf.sv
// Store miss merge buffer top: routes stores to an open entry for their
// line or to a free entry, stalls stores to closed lines or when full,
// and arbitrates the bus request and cache write ports among entries.
// Assumes: the bus returns each fill with the tag of its request; stores
// are doubleword aligned.
module store_merge_buf #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    parameter int ENTRIES    = 4,
    parameter int TIMEOUT    = 16,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int SLOT_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int WA_W      = ADDR_W - $clog2(WORD_BYTES),
    localparam int LA_W      = WA_W - SLOT_W,
    localparam int IW        = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [WA_W-1:0]       st_waddr,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic [WORD_W-1:0]     st_data,
    output logic                  st_ready,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_kind,
    output logic [LA_W-1:0]       bus_req_line,
    output logic [IW-1:0]         bus_req_tag,
    input  logic                  fill_valid,
    input  logic [IW-1:0]         fill_tag,
    input  logic [LINE_W-1:0]     fill_data,
    output logic                  cw_valid,
    input  logic                  cw_ready,
    output logic [LA_W-1:0]       cw_line,
    output logic [LINE_W-1:0]     cw_data
);
    import smb_pkg::*;

    ent_st_t             ent_st   [ENTRIES];
    logic [LA_W-1:0]     ent_line [ENTRIES];
    logic [LINE_W-1:0]   ent_data [ENTRIES];
    logic [ENTRIES-1:0]  ent_kind;

    logic [LA_W-1:0]     st_line;
    logic [SLOT_W-1:0]   st_slot;
    logic [ENTRIES-1:0]  hit_open, hit_busy;
    logic [ENTRIES-1:0]  free_vec, req_vec, wb_vec;
    logic                free_any, bus_any, wb_any;
    logic [IW-1:0]       free_idx, bus_idx, wb_idx;
    logic                st_take;

    assign st_line = st_waddr[WA_W-1:SLOT_W];
    assign st_slot = st_waddr[SLOT_W-1:0];

    // Look the store's line up in every entry.
    smb_match #(.N(ENTRIES), .LA_W(LA_W)) u_match (
        .probe_line (st_line),
        .st_vec     (ent_st),
        .line_vec   (ent_line),
        .hit_open   (hit_open),
        .hit_busy   (hit_busy)
    );

    // Classify entries for the three pickers.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            free_vec[i] = (ent_st[i] == E_FREE);
            req_vec[i]  = (ent_st[i] == E_REQ);
            wb_vec[i]   = (ent_st[i] == E_WB);
        end
    end

    // Accept on an open hit, or on a fresh line while an entry is free.
    assign st_ready = (|hit_open) | (~(|hit_busy) & free_any);
    assign st_take  = st_valid & st_ready;

    smb_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (
        .clk(clk), .rst_n(rst_n), .req(free_vec), .ack(st_take),
        .any(free_any), .idx(free_idx)
    );

    smb_pick #(.N(ENTRIES), .IW(IW)) u_bus_pick (
        .clk(clk), .rst_n(rst_n), .req(req_vec), .ack(bus_req_ready),
        .any(bus_any), .idx(bus_idx)
    );

    smb_pick #(.N(ENTRIES), .IW(IW)) u_wb_pick (
        .clk(clk), .rst_n(rst_n), .req(wb_vec), .ack(cw_ready),
        .any(wb_any), .idx(wb_idx)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic alloc_i, merge_i, issue_i, fill_i, wb_i;
        // Per-entry strobes derived from the pickers and handshakes.
        assign alloc_i = st_take & ~(|hit_open) & (free_idx == IW'(i));
        assign merge_i = st_take & hit_open[i];
        assign issue_i = bus_any & bus_req_ready & (bus_idx == IW'(i));
        assign fill_i  = fill_valid & (fill_tag == IW'(i)) & (ent_st[i] == E_WAIT);
        assign wb_i    = wb_any & cw_ready & (wb_idx == IW'(i));

        smb_entry #(
            .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
            .LA_W(LA_W), .TIMEOUT(TIMEOUT)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_i),
            .merge     (merge_i),
            .st_line   (st_line),
            .st_slot   (st_slot),
            .st_be     (st_be),
            .st_data   (st_data),
            .issue_gnt (issue_i),
            .fill_hit  (fill_i),
            .fill_data (fill_data),
            .wb_done   (wb_i),
            .st_o      (ent_st[i]),
            .line_o    (ent_line[i]),
            .kind_o    (ent_kind[i]),
            .data_o    (ent_data[i])
        );
    end

    assign bus_req_valid = bus_any;
    assign bus_req_kind  = ent_kind[bus_idx];
    assign bus_req_line  = ent_line[bus_idx];
    assign bus_req_tag   = bus_idx;

    assign cw_valid = wb_any;
    assign cw_line  = ent_line[wb_idx];
    assign cw_data  = ent_data[wb_idx];
endmodule

// File: rtl/smb_chk.sv
// Port-level property checker for the store miss merge buffer.
module smb_chk #(
    parameter int LA_W   = 27,
    parameter int IW     = 2,
    parameter int LINE_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LA_W-1:0]   probe_line,
    input logic              st_ready,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic              bus_req_kind,
    input logic [LA_W-1:0]   bus_req_line,
    input logic [IW-1:0]     bus_req_tag,
    input logic              cw_valid,
    input logic              cw_ready,
    input logic [LA_W-1:0]   cw_line,
    input logic [LINE_W-1:0] cw_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!bus_req_valid && !cw_valid && st_ready));

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_line)
            && $stable(bus_req_kind) && $stable(bus_req_tag)));

    // R9
    cw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_line) && $stable(cw_data)));

    // R7
    req_line_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && (probe_line == bus_req_line)) |-> !st_ready);

    // R7
    wb_line_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && (probe_line == cw_line)) |-> !st_ready);
endmodule

bind store_merge_buf smb_chk #(.LA_W(LA_W), .IW(IW), .LINE_W(LINE_W)) u_smb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .probe_line    (st_line),
    .st_ready      (st_ready),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_kind  (bus_req_kind),
    .bus_req_line  (bus_req_line),
    .bus_req_tag   (bus_req_tag),
    .cw_valid      (cw_valid),
    .cw_ready      (cw_ready),
    .cw_line       (cw_line),
    .cw_data       (cw_data)
);

// File: tb/store_merge_buf_test.sv
`timescale 1ns/1ps
module store_merge_buf_test;
    localparam int ADDR_W = 32, LINE_BYTES = 32, WORD_BYTES = 8, ENTRIES = 4, TIMEOUT = 16;
    localparam int LINE_W = 256, WORD_W = 64, WA_W = 29, LA_W = 27, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, st_ready;
    logic [WA_W-1:0] st_waddr = '0;
    logic [WORD_BYTES-1:0] st_be = '0;
    logic [WORD_W-1:0] st_data = '0;
    logic bus_req_valid, bus_req_ready = 1'b0, bus_req_kind;
    logic [LA_W-1:0] bus_req_line;
    logic [IW-1:0] bus_req_tag;
    logic fill_valid = 1'b0;
    logic [IW-1:0] fill_tag = '0;
    logic [LINE_W-1:0] fill_data = '0;
    logic cw_valid, cw_ready = 1'b0;
    logic [LA_W-1:0] cw_line;
    logic [LINE_W-1:0] cw_data;

    int n_vec = 0, n_bad = 0, n_bus = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    store_merge_buf #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
                      .ENTRIES(ENTRIES), .TIMEOUT(TIMEOUT)) uut (.*);

    // Count accepted bus transactions.
    always @(posedge clk) if (rst_n && bus_req_valid && bus_req_ready) n_bus++;

    task automatic chk(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, want %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic store(input logic [LA_W-1:0] line, input logic [1:0] slot,
                         input logic [7:0] be, input logic [63:0] data);
        st_waddr = {line, slot}; st_be = be; st_data = data; st_valid = 1'b1;
        #1;
        while (!st_ready) step();
        step();
        st_valid = 1'b0;
    endtask

    task automatic grant_bus();
        bus_req_ready = 1'b1; step(); bus_req_ready = 1'b0;
    endtask

    task automatic give_fill(input logic [IW-1:0] tag, input logic [LINE_W-1:0] data);
        fill_valid = 1'b1; fill_tag = tag; fill_data = data; step(); fill_valid = 1'b0;
    endtask

    task automatic take_cw();
        cw_ready = 1'b1; step(); cw_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) step(); rst_n = 1'b1; step();
        chk("R1 st_ready", st_ready, 1);
        chk("R1 bus_req_valid", bus_req_valid, 0);
        chk("R1 cw_valid", cw_valid, 0);
    endtask

    task automatic t_claim();
        logic [LA_W-1:0] ln = 27'h80;
        logic [LINE_W-1:0] exp = '0;
        int base = n_bus;
        for (int k = 0; k < 4; k++) exp[k*64 +: 64] = 64'h0101_0101_0000_0000 * (k + 1) + 64'(k);
        for (int k = 0; k < 3; k++) store(ln, 2'(k), 8'hFF, exp[k*64 +: 64]);
        chk("R2 no request while merging", bus_req_valid, 0);
        store(ln, 2'd3, 8'hFF, exp[3*64 +: 64]);
        chk("R3 request after full cover", bus_req_valid, 1);
        chk("R3 kind claim", bus_req_kind, 1);
        chk("R3 line", bus_req_line, ln);
        grant_bus();
        chk("R3 cw_valid", cw_valid, 1);
        chk("R3 cw_line", cw_line, ln);
        chk("R3 cw_data", cw_data, exp);
        take_cw();
        chk("R2 single bus transaction", n_bus - base, 1);
        chk("R3 retired", cw_valid, 0);
    endtask

    task automatic t_partial();
        logic [LA_W-1:0] ln = 27'h102;
        logic [63:0] x = 64'h1111_2222_3333_4444, y = 64'hAAAA_BBBB_CCCC_DDDD;
        logic [LINE_W-1:0] f = {8{32'hF0F1_F2F3}};
        logic [LINE_W-1:0] exp;
        logic [IW-1:0] tag;
        exp = f;
        exp[64 +: 32] = x[31:0];
        exp[64 +: 16] = y[15:0];
        store(ln, 2'd1, 8'h0F, x);
        store(ln, 2'd1, 8'h03, y);
        repeat (TIMEOUT - 2) step();
        chk("R6 no request before timeout", bus_req_valid, 0);
        step();
        chk("R6 request at timeout", bus_req_valid, 1);
        chk("R4 kind read", bus_req_kind, 0);
        chk("R4 line", bus_req_line, ln);
        tag = bus_req_tag;
        grant_bus();
        chk("R4 no write before fill", cw_valid, 0);
        give_fill(tag, f);
        chk("R4 cw_valid", cw_valid, 1);
        chk("R5 youngest byte wins, R4 override", cw_data, exp);
        take_cw();
    endtask

    task automatic t_closed_stall();
        logic [LA_W-1:0] ln = 27'h155;
        logic [LINE_W-1:0] exp;
        logic [IW-1:0] tag;
        for (int k = 0; k < 4; k++) store(ln, 2'(k), 8'hFF, 64'(k));
        st_waddr = {ln, 2'd0}; st_be = 8'h01; st_data = 64'h5A; st_valid = 1'b1; #1;
        chk("R7 stall while requesting", st_ready, 0);
        step(); step();
        chk("R7 stall still", st_ready, 0);
        bus_req_ready = 1'b1; step(); bus_req_ready = 1'b0;
        chk("R7 stall during write", st_ready, 0);
        cw_ready = 1'b1; step(); cw_ready = 1'b0;
        chk("R7 accepted after retire", st_ready, 1);
        step();
        st_valid = 1'b0;
        while (!bus_req_valid) step();
        chk("R7 new entry read", bus_req_kind, 0);
        tag = bus_req_tag;
        grant_bus();
        give_fill(tag, '0);
        exp = '0; exp[7:0] = 8'h5A;
        chk("R7 new entry data", cw_data, exp);
        take_cw();
    endtask

    task automatic t_full();
        logic [LA_W-1:0] base = 27'h200;
        logic [63:0] m = 64'hDEAD_BEEF_0BAD_F00D;
        logic [LINE_W-1:0] exp;
        for (int k = 0; k < 4; k++) store(base + LA_W'(k), 2'd0, 8'h01, 64'(k + 1));
        st_waddr = {27'h2FF, 2'd0}; st_be = 8'hFF; st_data = '0; st_valid = 1'b1; #1;
        chk("R8 stall new line when full", st_ready, 0);
        st_waddr = {base + 27'd1, 2'd2}; st_data = m; #1;
        chk("R8 open line accepted when full", st_ready, 1);
        step();
        st_valid = 1'b0;
        repeat (TIMEOUT + 2) step();
        for (int k = 0; k < 4; k++) begin
            chk("R9 lowest index first", bus_req_tag, k);
            chk("R9 request line", bus_req_line, base + LA_W'(k));
            grant_bus();
        end
        for (int k = 3; k >= 0; k--) begin
            exp = {32{8'(8'h10 + k)}};
            exp[7:0] = 8'(k + 1);
            if (k == 1) exp[128 +: 64] = m;
            give_fill(IW'(k), {32{8'(8'h10 + k)}});
            chk("R10 fill routed line", cw_line, base + LA_W'(k));
            chk("R10 fill routed data", cw_data, exp);
            take_cw();
        end
    endtask

    initial begin
        t_reset();
        t_claim();
        t_partial();
        t_closed_stall();
        t_full();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog (all requirements): got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule